// File: doc/BRIEF.md
# Cycle-Synchronous Event Sequencer Transmitter

This block is the sending end of a timing network. It drives one serial line that carries 8-bit event codes to downstream receivers. The line is Manchester coded, and its bit rate is locked to the reference clock. A cycle pulse arrives once per machine cycle. It restarts a schedule table of (tick offset, event code) entries, with offsets counted in reference-clock ticks from that pulse. Rising edges on external trigger inputs add event codes of their own, which are merged into the same line.

Each event goes out as a frame: a start bit of 1, then the eight code bits with the MSB first. Between frames the line carries an unbroken run of Manchester zero bits, so receivers always see transitions to lock onto. Code 0x00 is the idle code and is never framed. In the schedule table, code 0x00 marks the end of the programmed sequence. The table is loaded through a simple write port between cycles.

Scheduled events have priority over trigger events. Trigger events wait in a small FIFO until a frame slot is free.

Top module: `evt_seq_tx`

## Requirements
- R1: After reset the line carries only Manchester zero bits and no frame. Bit k begins after 2*HALF_TICKS*k clock edges, counted from reset release, so `line_o` is low in the first tick after reset.
- R2: Every bit lasts 2*HALF_TICKS clocks. A 1 is sent high for the first half and low for the second. A 0 is sent low for the first half and high for the second. The line therefore changes level at the middle of every bit.
- R3: A frame is 9 bits: a start bit of 1, then code bits 7 down to 0. Another frame may begin at the bit boundary right after the last code bit.
- R4: When `cycle_i` is sampled high at a clock edge, the tick counter restarts at 0 after that edge. An entry with offset O becomes due O clocks after that edge. If the line is free, its frame starts at the first bit boundary strictly after the tick in which it became due.
- R5: Entries are sent in table order, starting at index 0. The sequence stops at the first entry whose code is 0x00, or after entry DEPTH-1. Code 0x00 is never sent.
- R6: A new `cycle_i` pulse restarts the sequence from entry 0 with the tick counter at 0. Entries of the old sequence that were not yet sent are dropped.
- R7: A rising edge on `trig_i[i]` sends the code TRIG_CODE0+i (default 0xF0+i). The event becomes due one clock after the edge that first samples the input high. Holding the input high produces no further event.
- R8: Triggers that rise together are sent lowest index first, one frame each, back to back.
- R9: When a scheduled event and a trigger event are both due at a bit boundary, the scheduled frame is sent first. The trigger frame follows at the next frame slot.
- R10: A write with `cfg_we_i` high stores `cfg_offs_i` and `cfg_code_i` as entry `cfg_idx_i` of the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock; one tick per period |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | 1 | Machine-cycle pulse, synchronous to clk_i |
| trig_i | input | N_TRIG | External trigger inputs, synchronous to clk_i |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_idx_i | input | clog2(DEPTH) | Table entry index |
| cfg_offs_i | input | OFFS_W | Tick offset of the entry |
| cfg_code_i | input | 8 | Event code of the entry (0x00 ends the sequence) |
| line_o | output | 1 | Manchester-coded serial event line |

## Verification
The bench builds the block with its default parameters: 16 table entries, 24-bit offsets, four triggers, a 4-deep trigger FIFO and 2-tick half bits. With these values a full 16-entry sequence can be run. Firing all four triggers at once fills the FIFO exactly. The 4-tick bit period lets due ticks fall on every phase of a bit, so the rule that a frame starts at the next boundary is tested at each phase. The bench decodes the line itself and compares each frame's code and start tick with values worked out from the cycle-pulse and trigger times.

// File: rtl/evt_seq_pkg.sv
package evt_seq_pkg;
  localparam int unsigned CODE_W = 8;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t IDLE_CODE = '0;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_SCHED,
    SRC_TRIG
  } src_e;
endpackage

// File: rtl/evt_sched.sv
module evt_sched
  import evt_seq_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned OFFS_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cfg_we_i,
  input  logic [$clog2(DEPTH)-1:0] cfg_idx_i,
  input  logic [OFFS_W-1:0]        cfg_offs_i,
  input  code_t                    cfg_code_i,
  input  logic                     cycle_i,
  input  logic                     take_i,
  output logic                     due_o,
  output code_t                    code_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned IW = $clog2(DEPTH + 1);
  localparam logic [IW-1:0] IDX_END = IW'(DEPTH);

  logic [OFFS_W-1:0] offs_q [DEPTH];
  code_t             code_q [DEPTH];
  logic [IW-1:0]     idx_q;
  logic [OFFS_W-1:0] cnt_q;
  logic              run_q;
  logic              at_end;
  code_t             cur_code;
  logic [OFFS_W-1:0] cur_offs;

  always_comb begin
    at_end   = (idx_q == IDX_END);
    cur_code = at_end ? IDLE_CODE : code_q[idx_q[AW-1:0]];
    cur_offs = at_end ? '0 : offs_q[idx_q[AW-1:0]];
  end

  // entry stays due until taken; line contention only delays it
  assign due_o  = run_q && (cur_code != IDLE_CODE) && (cnt_q >= cur_offs);
  assign code_o = cur_code;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        offs_q[i] <= '0;
        code_q[i] <= IDLE_CODE;
      end
    end else if (cfg_we_i) begin
      offs_q[cfg_idx_i] <= cfg_offs_i;
      code_q[cfg_idx_i] <= cfg_code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (cycle_i) begin
      run_q <= 1'b1;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (run_q) begin
      if (at_end || cur_code == IDLE_CODE) begin
        run_q <= 1'b0;
      end else begin
        if (take_i) idx_q <= idx_q + 1'b1;
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R6
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_i |=> (idx_q == '0 && cnt_q == '0));

  // R4
  take_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> due_o);

  // R5
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !cycle_i) |=> (idx_q == $past(idx_q) || idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/evt_trig_in.sv
module evt_trig_in
  import evt_seq_pkg::*;
#(
  parameter int unsigned N_TRIG     = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter code_t       TRIG_CODE0 = 8'hF0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              pop_i,
  output logic              valid_o,
  output code_t             code_o
);
  localparam int unsigned PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);
  localparam logic [PW-1:0] PTR_LAST = PW'(FIFO_DEPTH - 1);

  logic [N_TRIG-1:0] prev_q, pend_q, rise, clr;
  code_t             mem_q [FIFO_DEPTH];
  logic [PW-1:0]     wp_q, rp_q;
  logic [CW-1:0]     cnt_q;
  logic              push;
  code_t             push_code;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_edge
    assign rise[g] = trig_i[g] & ~prev_q[g];

    // R7
    edge_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trig_i[g] && !prev_q[g]) |=> pend_q[g]);
  end

  // lowest pending index moves into the FIFO, one per tick
  always_comb begin
    push      = 1'b0;
    push_code = IDLE_CODE;
    clr       = '0;
    if (cnt_q != FULL_CNT) begin
      for (int i = N_TRIG - 1; i >= 0; i--) begin
        if (pend_q[i]) begin
          push      = 1'b1;
          push_code = TRIG_CODE0 + code_t'(i);
          clr       = '0;
          clr[i]    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= trig_i;
      pend_q <= (pend_q & ~clr) | rise;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < FIFO_DEPTH; i++) mem_q[i] <= IDLE_CODE;
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        mem_q[wp_q] <= push_code;
        wp_q        <= (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
      end
      if (pop_i) rp_q <= (rp_q == PTR_LAST) ? '0 : rp_q + 1'b1;
      case ({push, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign valid_o = (cnt_q != '0);
  assign code_o  = mem_q[rp_q];

  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL_CNT);

  // R7
  pop_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> cnt_q != '0);
endmodule

// File: rtl/evt_manch_ser.sv
module evt_manch_ser
  import evt_seq_pkg::*;
#(
  parameter int unsigned HALF_TICKS = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ld_valid_i,
  input  code_t ld_code_i,
  output logic  take_o,
  output logic  line_o
);
  localparam int unsigned HC_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
  localparam int unsigned BW   = $clog2(CODE_W + 1);
  localparam logic [HC_W-1:0] HC_LAST  = HC_W'(HALF_TICKS - 1);
  localparam logic [BW-1:0]   BIT_LAST = BW'(CODE_W);

  logic [HC_W-1:0] hc_q;
  logic            slot_q;
  logic            busy_q;
  logic [BW-1:0]   bcnt_q;
  logic [CODE_W:0] sh_q;
  logic            bit_end, can_load;

  assign bit_end  = slot_q && (hc_q == HC_LAST);
  assign can_load = bit_end && (!busy_q || bcnt_q == BIT_LAST);
  assign take_o   = can_load && ld_valid_i;
  // idle sends zeros; second half is the inverse of the first
  assign line_o   = (busy_q & sh_q[CODE_W]) ^ slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q   <= '0;
      slot_q <= 1'b0;
      busy_q <= 1'b0;
      bcnt_q <= '0;
      sh_q   <= '0;
    end else begin
      if (hc_q == HC_LAST) begin
        hc_q   <= '0;
        slot_q <= ~slot_q;
      end else begin
        hc_q <= hc_q + 1'b1;
      end
      if (can_load) begin
        if (ld_valid_i) begin
          sh_q   <= {1'b1, ld_code_i};
          bcnt_q <= '0;
          busy_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end else if (bit_end && busy_q) begin
        sh_q   <= {sh_q[CODE_W-1:0], 1'b0};
        bcnt_q <= bcnt_q + 1'b1;
      end
    end
  end

  // R2
  mid_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q && hc_q == '0) |-> line_o != $past(line_o));

  // R2
  half_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hc_q != '0) |-> $stable(line_o));

  // R3
  start_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> (line_o && !slot_q));

  // R3
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> bcnt_q <= BIT_LAST);
endmodule

// File: rtl/evt_seq_tx.sv
module evt_seq_tx
  import evt_seq_pkg::*;
#(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned OFFS_W     = 24,
  parameter int unsigned N_TRIG     = 4,
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned HALF_TICKS = 2,
  parameter code_t       TRIG_CODE0 = 8'hF0
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     cycle_i,
  input  logic [N_TRIG-1:0]        trig_i,
  input  logic                     cfg_we_i,
  input  logic [$clog2(DEPTH)-1:0] cfg_idx_i,
  input  logic [OFFS_W-1:0]        cfg_offs_i,
  input  logic [CODE_W-1:0]        cfg_code_i,
  output logic                     line_o
);
  logic  s_due, t_valid, take, s_take, t_pop, ld_valid;
  code_t s_code, t_code, ld_code;
  src_e  src;

  always_comb begin
    src = SRC_NONE;
    if (s_due)        src = SRC_SCHED;
    else if (t_valid) src = SRC_TRIG;
  end

  assign ld_valid = (src != SRC_NONE);
  assign ld_code  = (src == SRC_TRIG) ? t_code : s_code;
  assign s_take   = take && (src == SRC_SCHED);
  assign t_pop    = take && (src == SRC_TRIG);

  evt_sched #(.DEPTH(DEPTH), .OFFS_W(OFFS_W)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_idx_i  (cfg_idx_i),
    .cfg_offs_i (cfg_offs_i),
    .cfg_code_i (cfg_code_i),
    .cycle_i    (cycle_i),
    .take_i     (s_take),
    .due_o      (s_due),
    .code_o     (s_code)
  );

  evt_trig_in #(.N_TRIG(N_TRIG), .FIFO_DEPTH(FIFO_DEPTH), .TRIG_CODE0(TRIG_CODE0)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (trig_i),
    .pop_i   (t_pop),
    .valid_o (t_valid),
    .code_o  (t_code)
  );

  evt_manch_ser #(.HALF_TICKS(HALF_TICKS)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_valid_i (ld_valid),
    .ld_code_i  (ld_code),
    .take_o     (take),
    .line_o     (line_o)
  );

  // R9
  sched_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_due && t_valid && take) |-> !t_pop);

  // R5
  no_idle_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take |-> ld_code != IDLE_CODE);
endmodule

// File: tb/sim_evt_seq_tx.sv
`timescale 1ns/100ps
module sim_evt_seq_tx;
  localparam int HALF  = 2;
  localparam int BIT   = 2 * HALF;
  localparam int FRAME = 9 * BIT;
  localparam int NT    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cycle = 1'b0;
  logic [NT-1:0] trig = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [23:0]   cfg_offs = '0;
  logic [7:0]    cfg_code = '0;
  logic          line;

  always #2.5 clk = ~clk;

  evt_seq_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cycle), .trig_i(trig),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_offs_i(cfg_offs),
    .cfg_code_i(cfg_code), .line_o(line)
  );

  int tick = 0;
  always @(posedge clk) if (rst_n) tick <= tick + 1;

  // line decoder
  int rx_n = 0, code_err = 0, in_fr = 0, nb = 0, fst = 0;
  logic h0 = 1'b0;
  logic [7:0] sh = '0;
  int rx_code [64];
  int rx_tick [64];
  always @(negedge clk) if (rst_n) begin
    if (tick % BIT == 0) h0 = line;
    else if (tick % BIT == HALF) begin
      if (h0 == line) code_err++;
      if (in_fr == 0) begin
        if (h0) begin in_fr = 1; nb = 0; fst = tick - HALF; end
      end else begin
        sh = {sh[6:0], h0};
        nb++;
        if (nb == 8) begin
          if (rx_n < 64) begin rx_code[rx_n] = sh; rx_tick[rx_n] = fst; end
          rx_n++;
          in_fr = 0;
        end
      end
    end
  end

  int n_chk = 0, n_fail = 0, e_n = 0;
  int e_code [64];
  int e_tick [64];
  bit done = 0;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int exp_start(input int due);
    return (due / BIT + 1) * BIT;
  endfunction

  task automatic clear_log();
    rx_n = 0;
    e_n  = 0;
  endtask

  task automatic add_exp(input int code, input int t);
    e_code[e_n] = code;
    e_tick[e_n] = t;
    e_n++;
  endtask

  task automatic verify(input string req);
    chk({req, " frame count"}, rx_n, e_n);
    for (int i = 0; i < e_n && i < rx_n; i++) begin
      chk({req, " code"}, rx_code[i], e_code[i]);
      chk({req, " start tick"}, rx_tick[i], e_tick[i]);
    end
  endtask

  task automatic wr(input int idx, input int offs, input int code);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_offs = 24'(offs); cfg_code = 8'(code);
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic pulse(output int p);
    @(posedge clk); #1;
    p = tick + 1;
    cycle = 1'b1;
    @(posedge clk); #1;
    cycle = 1'b0;
  endtask

  task automatic wait_until(input int t);
    while (tick < t) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p, p2, q, t0, last, n, off;
    int ec [16];
    int eo [16];
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: idle after reset
    @(negedge clk);
    chk("R1 line low in first tick", line, 0);
    wait_until(200);
    chk("R1 no frame while idle", rx_n, 0);
    chk("R2 idle coding", code_err, 0);

    // R4 R3 R10: basic schedule, offset 0 included
    clear_log();
    wr(0, 0, 8'hA5); wr(1, 40, 8'h3C); wr(2, 96, 8'h81); wr(3, 0, 0);
    pulse(p);
    add_exp(8'hA5, exp_start(p));
    add_exp(8'h3C, exp_start(p + 40));
    add_exp(8'h81, exp_start(p + 96));
    wait_until(p + 96 + FRAME + 2 * BIT);
    verify("R4 basic");
    if (rx_n >= 3) chk("R4 tick spacing", rx_tick[2] - rx_tick[1], 56);

    // R5: code 0x00 terminates, later entry not sent
    clear_log();
    wr(0, 4, 8'h11); wr(1, 61, 8'h22); wr(2, 110, 8'h33); wr(3, 0, 0); wr(4, 200, 8'h55);
    pulse(p);
    add_exp(8'h11, exp_start(p + 4));
    add_exp(8'h22, exp_start(p + 61));
    add_exp(8'h33, exp_start(p + 110));
    wait_until(p + 300);
    verify("R5 terminator");

    // R5: full table of 16 entries
    clear_log();
    for (int i = 0; i < 16; i++) wr(i, 8 + 44 * i, i + 1);
    pulse(p);
    for (int i = 0; i < 16; i++) add_exp(i + 1, exp_start(p + 8 + 44 * i));
    wait_until(p + 8 + 44 * 15 + FRAME + 3 * BIT);
    verify("R5 full table");

    // R6: restart drops unsent entries
    clear_log();
    wr(0, 8, 8'hA1); wr(1, 300, 8'hA2); wr(2, 0, 0);
    pulse(p);
    wait_until(p + 100);
    pulse(p2);
    add_exp(8'hA1, exp_start(p + 8));
    add_exp(8'hA1, exp_start(p2 + 8));
    add_exp(8'hA2, exp_start(p2 + 300));
    wait_until(p2 + 300 + FRAME + 3 * BIT);
    verify("R6 restart");

    // R7: single trigger, level held gives one event
    clear_log();
    wr(0, 0, 0);
    @(posedge clk); #1;
    q = tick; trig[2] = 1'b1;
    add_exp(8'hF2, exp_start(q + 2));
    repeat (200) @(posedge clk);
    #1 trig[2] = 1'b0;
    repeat (20) @(posedge clk);
    #1 q = tick; trig[2] = 1'b1;
    add_exp(8'hF2, exp_start(q + 2));
    repeat (10) @(posedge clk);
    #1 trig[2] = 1'b0;
    wait_until(q + FRAME + 3 * BIT);
    verify("R7 trigger edge");

    // R8: all triggers together
    clear_log();
    @(posedge clk); #1;
    q = tick; trig = '1;
    t0 = exp_start(q + 2);
    for (int i = 0; i < NT; i++) add_exp(8'hF0 + i, t0 + i * FRAME);
    repeat (10) @(posedge clk);
    #1 trig = '0;
    wait_until(t0 + NT * FRAME + 3 * BIT);
    verify("R8 simultaneous");

    // R9: scheduled and trigger due in the same tick
    clear_log();
    wr(0, 1, 8'h5A); wr(1, 0, 0);
    @(posedge clk); #1;
    q = tick; p = q + 1; cycle = 1'b1; trig[1] = 1'b1;
    @(posedge clk); #1;
    cycle = 1'b0;
    t0 = exp_start(p + 1);
    add_exp(8'h5A, t0);
    add_exp(8'hF1, t0 + FRAME);
    repeat (10) @(posedge clk);
    #1 trig[1] = 1'b0;
    wait_until(t0 + 2 * FRAME + 3 * BIT);
    verify("R9 priority");

    // R4 R5: random schedules
    for (int r = 0; r < 8; r++) begin
      clear_log();
      n = $urandom_range(16, 1);
      off = $urandom_range(20, 0);
      for (int i = 0; i < n; i++) begin
        ec[i] = $urandom_range(255, 1);
        eo[i] = off;
        wr(i, off, ec[i]);
        off += 40 + 4 * $urandom_range(6, 0);
      end
      if (n < 16) wr(n, 0, 0);
      pulse(p);
      for (int i = 0; i < n; i++) add_exp(ec[i], exp_start(p + eo[i]));
      last = p + eo[n - 1];
      wait_until(last + FRAME + 3 * BIT);
      verify("R4 random schedule");
    end

    chk("R2 manchester coding overall", code_err, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule